// File: doc/BRIEF.md
# Exact-Sharer Directory Coherence Controller

This controller keeps coherence bookkeeping for one bank of an inclusive shared last-level cache. For every block in the bank it holds a stable state (Invalid, Shared or Modified) and an exact sharer mask with one bit per core. Private caches report every eviction to it, including clean ones. Because of this, every invalidation and every recall it sends reaches a core that really holds a copy.

Private caches send read, write, clean-eviction and dirty-writeback requests. The controller answers with data grants and acks. Where other copies have to be removed first, it sends invalidations, forwards or recalls, and it tracks the acks until all of them have returned. The shared cache names its victim blocks on a separate input. The controller recalls all private copies of a victim before it reports the victim as free, so inclusion holds.

One multi-ack transaction is in flight at a time. While it waits, both request inputs are stalled. Outgoing messages are registered and carry a destination core mask and a size in bytes.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every entry is Invalid with an empty sharer mask, no message is valid, `vic_done_o` is low and both ready outputs are high.
- R2: A write (`req_type_i`=1) by core k to a block that no other core holds completes in the acceptance cycle. The controller sends a modified grant (`msg_type_o`=2) with `msg_dest_o` having only bit k set (bit k of a mask is core k), and the entry becomes Modified owned only by k. This covers a sole sharer upgrading its copy.
- R3: A read (`req_type_i`=0) by core k to an Invalid or Shared block returns a shared grant (`msg_type_o`=1) to k and adds k to the sharers.
- R4: A write by core k to a block held by other cores sends one invalidation message (`msg_type_o`=3) whose mask lists every holder except k. It then waits for all their acks, grants Modified to k, and keeps k as the only sharer.
- R5: A read by core k to a block that another core owns Modified sends a forward (`msg_type_o`=4) to the owner. When the owner responds, k gets a shared grant and the entry becomes Shared with both bits set.
- R6: A clean eviction (`req_type_i`=2) clears the evicting core's bit and is answered with an ack (`msg_type_o`=6). When the mask becomes empty the entry returns to Invalid.
- R7: A dirty writeback (`req_type_i`=3) sets the entry to Invalid with an empty mask and is answered with an ack.
- R8: A victim with a non-empty mask causes a recall (`msg_type_o`=5) to exactly the sharer mask. `vic_done_o` pulses in the cycle after the last recall ack is taken, and the entry becomes Invalid. A victim with an empty mask pulses `vic_done_o` in the cycle after acceptance and sends no message.
- R9: Shared and modified grants report 72 bytes in `msg_bytes_o`. All other messages report 8 bytes.
- R10: While acks are outstanding, `req_ready_o` and `vic_ready_o` are low and no new request or victim is taken.
- R11: An ack from a core that is not in the outstanding set is ignored. The pending grant or release is issued by the edge that takes the last expected ack.
- R12: When a victim and a request are both valid in an idle cycle, the victim is taken first and `req_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request from a private cache is valid |
| req_ready_o | output | 1 | Request accepted on this edge when high |
| req_type_i | input | 2 | 0 read, 1 write, 2 clean eviction, 3 dirty writeback |
| req_core_i | input | CORE_W | Requesting core |
| req_blk_i | input | BLK_W | Block index of the request |
| vic_valid_i | input | 1 | Shared cache names a victim block |
| vic_ready_o | output | 1 | Victim accepted on this edge when high |
| vic_blk_i | input | BLK_W | Victim block index |
| vic_done_o | output | 1 | One-cycle pulse: victim is free |
| ack_valid_i | input | 1 | Ack or forwarded-data response from a core |
| ack_core_i | input | CORE_W | Core sending the ack |
| msg_valid_o | output | 1 | Outgoing message valid (one cycle) |
| msg_type_o | output | 3 | 1 shared grant, 2 modified grant, 3 invalidate, 4 forward, 5 recall, 6 ack |
| msg_dest_o | output | NUM_CORES | Destination core mask, bit k is core k |
| msg_blk_o | output | BLK_W | Block the message refers to |
| msg_bytes_o | output | 7 | Message size in bytes |

## Verification
The hardest state to reach from the ports is an open wait that receives an ack nobody asked for. The stimulus first gives a block a Modified owner, then issues a write from a different core, which opens a one-ack wait. While that wait is open it sends an ack from an unrelated core. The bench then checks that no grant appears and both ready outputs stay low. Only after that does the real owner ack, and the bench checks that the grant follows on that edge. Recall masks are used to make the hidden sharer masks visible. A victim is issued after a forward-then-share sequence and after a partial clean eviction, so the recall destination shows exactly which bits the directory holds.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {DS_INV = 2'd0, DS_SHR = 2'd1, DS_MOD = 2'd2} dstate_e;
  typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_WRITE = 2'd1, RQ_EVICT = 2'd2, RQ_WBACK = 2'd3} rq_e;
  typedef enum logic [2:0] {
    MT_NONE = 3'd0, MT_GNT_S = 3'd1, MT_GNT_M = 3'd2, MT_INV = 3'd3,
    MT_FWD = 3'd4, MT_RECALL = 3'd5, MT_ACK = 3'd6
  } mt_e;
  typedef enum logic [1:0] {PK_GNT_M = 2'd0, PK_GNT_S = 2'd1, PK_VICTIM = 2'd2} pend_e;
  typedef enum logic {FS_IDLE = 1'b0, FS_WAIT = 1'b1} fsm_e;
  localparam int unsigned CTRL_BYTES = 8;
  localparam int unsigned DATA_BYTES = 72;
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
  import dir_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned BLK_W     = 3,
  localparam int unsigned NUM_BLKS = 1 << BLK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BLK_W-1:0]     rd_blk_i,
  output dstate_e              rd_state_o,
  output logic [NUM_CORES-1:0] rd_sharers_o,
  input  logic                 wr_en_i,
  input  logic [BLK_W-1:0]     wr_blk_i,
  input  dstate_e              wr_state_i,
  input  logic [NUM_CORES-1:0] wr_sharers_i
);
  dstate_e              st_arr [NUM_BLKS];
  logic [NUM_CORES-1:0] sh_arr [NUM_BLKS];

  for (genvar g = 0; g < NUM_BLKS; g++) begin : g_ent
    dstate_e              st_q;
    logic [NUM_CORES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= DS_INV;
        sh_q <= '0;
      end else if (wr_en_i && (wr_blk_i == BLK_W'(g))) begin
        st_q <= wr_state_i;
        sh_q <= wr_sharers_i;
      end
    end
    assign st_arr[g] = st_q;
    assign sh_arr[g] = sh_q;
  end

  assign rd_state_o   = st_arr[rd_blk_i];
  assign rd_sharers_o = sh_arr[rd_blk_i];
endmodule

// File: rtl/dir_ack_tracker.sv
module dir_ack_tracker #(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned CNT_W  = $clog2(NUM_CORES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NUM_CORES-1:0] load_mask_i,
  input  logic                 ack_valid_i,
  input  logic [CORE_W-1:0]    ack_core_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [NUM_CORES-1:0] pend_o
);
  logic [CNT_W-1:0]     cnt_q, load_cnt;
  logic [NUM_CORES-1:0] pend_q;
  logic                 hit;

  always_comb begin
    load_cnt = '0;
    for (int i = 0; i < NUM_CORES; i++) load_cnt = load_cnt + CNT_W'(load_mask_i[i]);
  end

  assign hit = ack_valid_i && pend_q[ack_core_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (load_i) begin
      cnt_q  <= load_cnt;
      pend_q <= load_mask_i;
    end else if (hit) begin
      cnt_q              <= cnt_q - CNT_W'(1);
      pend_q[ack_core_i] <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/dir_msg_fmt.sv
module dir_msg_fmt
  import dir_pkg::*;
#(
  parameter int unsigned BYTES_W = 7
) (
  input  logic               valid_i,
  input  logic [2:0]         type_i,
  output logic [BYTES_W-1:0] bytes_o
);
  logic carries_data;
  assign carries_data = (type_i == MT_GNT_S) || (type_i == MT_GNT_M);

  always_comb begin
    if (!valid_i)          bytes_o = '0;
    else if (carries_data) bytes_o = BYTES_W'(DATA_BYTES);
    else                   bytes_o = BYTES_W'(CTRL_BYTES);
  end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned BLK_W     = 3,
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [1:0]           req_type_i,
  input  logic [CORE_W-1:0]    req_core_i,
  input  logic [BLK_W-1:0]     req_blk_i,
  input  logic                 vic_valid_i,
  output logic                 vic_ready_o,
  input  logic [BLK_W-1:0]     vic_blk_i,
  output logic                 vic_done_o,
  input  logic                 ack_valid_i,
  input  logic [CORE_W-1:0]    ack_core_i,
  output logic                 msg_valid_o,
  output logic [2:0]           msg_type_o,
  output logic [NUM_CORES-1:0] msg_dest_o,
  output logic [BLK_W-1:0]     msg_blk_o,
  output logic [6:0]           msg_bytes_o
);
  localparam int unsigned CNT_W = $clog2(NUM_CORES + 1);

  fsm_e                 fsm_q, fsm_d;
  pend_e                pkind_q, pkind_d;
  logic [BLK_W-1:0]     pblk_q;
  logic [NUM_CORES-1:0] preq_q, pkeep_q, pkeep_d;

  logic                 rq_fire, vc_fire;
  logic [BLK_W-1:0]     rd_blk;
  dstate_e              ent_st, wr_st;
  logic [NUM_CORES-1:0] ent_sh, wr_sh, req_bit, others;
  logic                 wr_en;
  logic [BLK_W-1:0]     wr_blk;

  logic                 trk_load;
  logic [NUM_CORES-1:0] trk_mask, trk_pend;
  logic [CNT_W-1:0]     trk_cnt;
  logic                 trk_last;

  logic                 mv_d, mv_q, done_d, done_q;
  mt_e                  mt_d, mt_q;
  logic [NUM_CORES-1:0] md_d, md_q;
  logic [BLK_W-1:0]     mb_d, mb_q;

  assign vic_ready_o = (fsm_q == FS_IDLE);
  assign req_ready_o = (fsm_q == FS_IDLE) && !vic_valid_i;  // victims first
  assign rq_fire     = req_valid_i && req_ready_o;
  assign vc_fire     = vic_valid_i && vic_ready_o;
  assign rd_blk      = vic_valid_i ? vic_blk_i : req_blk_i;
  assign req_bit     = NUM_CORES'(1) << req_core_i;
  assign others      = ent_sh & ~req_bit;
  assign trk_last    = ack_valid_i && trk_pend[ack_core_i] && (trk_cnt == CNT_W'(1));

  dir_entry_store #(.NUM_CORES(NUM_CORES), .BLK_W(BLK_W)) u_store (
    .clk_i, .rst_ni,
    .rd_blk_i(rd_blk), .rd_state_o(ent_st), .rd_sharers_o(ent_sh),
    .wr_en_i(wr_en), .wr_blk_i(wr_blk), .wr_state_i(wr_st), .wr_sharers_i(wr_sh)
  );

  dir_ack_tracker #(.NUM_CORES(NUM_CORES)) u_trk (
    .clk_i, .rst_ni,
    .load_i(trk_load), .load_mask_i(trk_mask),
    .ack_valid_i, .ack_core_i,
    .cnt_o(trk_cnt), .pend_o(trk_pend)
  );

  always_comb begin
    fsm_d    = fsm_q;
    pkind_d  = pkind_q;
    pkeep_d  = '0;
    wr_en    = 1'b0;
    wr_blk   = rd_blk;
    wr_st    = ent_st;
    wr_sh    = ent_sh;
    trk_load = 1'b0;
    trk_mask = '0;
    mv_d     = 1'b0;
    mt_d     = MT_NONE;
    md_d     = '0;
    mb_d     = rd_blk;
    done_d   = 1'b0;
    unique case (fsm_q)
      FS_IDLE: begin
        if (vc_fire) begin
          if (ent_sh == '0) begin
            done_d = 1'b1;
            wr_en  = 1'b1;
            wr_st  = DS_INV;
          end else begin
            mv_d = 1'b1; mt_d = MT_RECALL; md_d = ent_sh;
            trk_load = 1'b1; trk_mask = ent_sh;
            pkind_d = PK_VICTIM; fsm_d = FS_WAIT;
          end
        end else if (rq_fire) begin
          unique case (rq_e'(req_type_i))
            RQ_READ: begin
              if (ent_st == DS_MOD && others != '0) begin
                mv_d = 1'b1; mt_d = MT_FWD; md_d = ent_sh;
                trk_load = 1'b1; trk_mask = ent_sh;
                pkind_d = PK_GNT_S; pkeep_d = ent_sh; fsm_d = FS_WAIT;
              end else if (ent_st == DS_MOD) begin
                mv_d = 1'b1; mt_d = MT_GNT_M; md_d = req_bit;
              end else begin
                wr_en = 1'b1; wr_st = DS_SHR; wr_sh = ent_sh | req_bit;
                mv_d = 1'b1; mt_d = MT_GNT_S; md_d = req_bit;
              end
            end
            RQ_WRITE: begin
              if (others == '0) begin
                wr_en = 1'b1; wr_st = DS_MOD; wr_sh = req_bit;
                mv_d = 1'b1; mt_d = MT_GNT_M; md_d = req_bit;
              end else begin
                mv_d = 1'b1; mt_d = MT_INV; md_d = others;
                trk_load = 1'b1; trk_mask = others;
                pkind_d = PK_GNT_M; fsm_d = FS_WAIT;
              end
            end
            RQ_EVICT: begin
              wr_en = 1'b1; wr_sh = others;
              wr_st = (others == '0) ? DS_INV : ent_st;
              mv_d = 1'b1; mt_d = MT_ACK; md_d = req_bit;
            end
            RQ_WBACK: begin
              wr_en = 1'b1; wr_st = DS_INV; wr_sh = '0;
              mv_d = 1'b1; mt_d = MT_ACK; md_d = req_bit;
            end
            default: ;
          endcase
        end
      end
      FS_WAIT: begin
        if (trk_last) begin
          fsm_d  = FS_IDLE;
          wr_en  = 1'b1;
          wr_blk = pblk_q;
          mb_d   = pblk_q;
          unique case (pkind_q)
            PK_GNT_M: begin
              wr_st = DS_MOD; wr_sh = preq_q;
              mv_d = 1'b1; mt_d = MT_GNT_M; md_d = preq_q;
            end
            PK_GNT_S: begin
              wr_st = DS_SHR; wr_sh = pkeep_q | preq_q;
              mv_d = 1'b1; mt_d = MT_GNT_S; md_d = preq_q;
            end
            default: begin
              wr_st = DS_INV; wr_sh = '0; done_d = 1'b1;
            end
          endcase
        end
      end
      default: fsm_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= FS_IDLE;
      pkind_q <= PK_GNT_M;
      pblk_q  <= '0;
      preq_q  <= '0;
      pkeep_q <= '0;
      mv_q    <= 1'b0;
      mt_q    <= MT_NONE;
      md_q    <= '0;
      mb_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      mv_q   <= mv_d;
      mt_q   <= mt_d;
      md_q   <= md_d;
      mb_q   <= mb_d;
      done_q <= done_d;
      if (trk_load) begin
        pkind_q <= pkind_d;
        pblk_q  <= rd_blk;
        preq_q  <= vc_fire ? '0 : req_bit;
        pkeep_q <= pkeep_d;
      end
    end
  end

  dir_msg_fmt #(.BYTES_W(7)) u_fmt (
    .valid_i(mv_q), .type_i(mt_q), .bytes_o(msg_bytes_o)
  );

  assign msg_valid_o = mv_q;
  assign msg_type_o  = mt_q;
  assign msg_dest_o  = md_q;
  assign msg_blk_o   = mb_q;
  assign vic_done_o  = done_q;
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk
  import dir_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CNT_W = $clog2(NUM_CORES + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic                 vic_valid_i,
  input logic                 vic_ready_o,
  input logic                 vic_done_o,
  input logic                 ack_valid_i,
  input logic                 msg_valid_o,
  input logic [2:0]           msg_type_o,
  input logic [NUM_CORES-1:0] msg_dest_o,
  input logic [6:0]           msg_bytes_o,
  input logic [CNT_W-1:0]     trk_cnt,
  input logic [NUM_CORES-1:0] trk_pend
);
  logic is_gnt, is_wait_msg;
  assign is_gnt      = msg_valid_o && (msg_type_o == MT_GNT_S || msg_type_o == MT_GNT_M);
  assign is_wait_msg = msg_valid_o &&
                       (msg_type_o == MT_INV || msg_type_o == MT_FWD || msg_type_o == MT_RECALL);

  AST_GNT_DATA_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_gnt |-> msg_bytes_o == 7'd72);  // R9
  AST_CTRL_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !is_gnt) |-> msg_bytes_o == 7'd8);  // R9
  AST_GNT_ONE_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_gnt |-> $countones(msg_dest_o) == 1);  // R2
  AST_WAIT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wait_msg |-> (!req_ready_o && !vic_ready_o));  // R10
  AST_ACK_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(trk_cnt) == $countones(trk_pend));  // R11
  AST_DONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_done_o |-> !msg_valid_o);  // R8
  AST_MSG_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> ($past(req_valid_i && req_ready_o) || $past(ack_valid_i) ||
                     $past(vic_valid_i && vic_ready_o)));  // R11
endmodule

bind dir_ctrl dir_ctrl_chk #(.NUM_CORES(NUM_CORES)) u_dir_ctrl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .vic_valid_i(vic_valid_i), .vic_ready_o(vic_ready_o), .vic_done_o(vic_done_o),
  .ack_valid_i(ack_valid_i),
  .msg_valid_o(msg_valid_o), .msg_type_o(msg_type_o),
  .msg_dest_o(msg_dest_o), .msg_bytes_o(msg_bytes_o),
  .trk_cnt(trk_cnt), .trk_pend(trk_pend)
);

// File: tb/dir_ctrl_bench.sv
module dir_ctrl_bench;
  localparam int NC = 4;
  localparam int CW = 2;
  localparam int BW = 3;
  localparam int T_GS = 1, T_GM = 2, T_INV = 3, T_FWD = 4, T_RCL = 5, T_ACK = 6;
  localparam logic [1:0] Q_RD = 2'd0, Q_WR = 2'd1, Q_EV = 2'd2, Q_WB = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_type = '0;
  logic [CW-1:0] req_core = '0;
  logic [BW-1:0] req_blk = '0;
  logic          vic_valid = 1'b0;
  logic [BW-1:0] vic_blk = '0;
  logic          ack_valid = 1'b0;
  logic [CW-1:0] ack_core = '0;
  logic          req_ready, vic_ready, vic_done, msg_valid;
  logic [2:0]    msg_type;
  logic [NC-1:0] msg_dest;
  logic [BW-1:0] msg_blk;
  logic [6:0]    msg_bytes;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  int o_v, o_t, o_d, o_b, o_blk, o_done;

  always #5 clk = ~clk;

  dir_ctrl #(.NUM_CORES(NC), .BLK_W(BW)) u_dir_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_type_i(req_type),
    .req_core_i(req_core), .req_blk_i(req_blk),
    .vic_valid_i(vic_valid), .vic_ready_o(vic_ready), .vic_blk_i(vic_blk),
    .vic_done_o(vic_done),
    .ack_valid_i(ack_valid), .ack_core_i(ack_core),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type), .msg_dest_o(msg_dest),
    .msg_blk_o(msg_blk), .msg_bytes_o(msg_bytes)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic grab();
    o_v = int'(msg_valid); o_t = int'(msg_type); o_d = int'(msg_dest);
    o_b = int'(msg_bytes); o_blk = int'(msg_blk); o_done = int'(vic_done);
  endtask

  task automatic do_req(input logic [1:0] t, input int core, input int blk);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_core = CW'(core); req_blk = BW'(blk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    grab();
  endtask

  task automatic do_vic(input int blk);
    @(negedge clk);
    vic_valid = 1'b1; vic_blk = BW'(blk);
    while (!vic_ready) @(negedge clk);
    @(negedge clk);
    vic_valid = 1'b0;
    grab();
  endtask

  task automatic do_ack(input int core);
    @(negedge clk);
    ack_valid = 1'b1; ack_core = CW'(core);
    @(negedge clk);
    ack_valid = 1'b0;
    grab();
  endtask

  task automatic expect_msg(input string rq, input int t, input int d, input int bytes);
    chk(rq, "msg_valid", o_v, 1);
    chk(rq, "msg_type", o_t, t);
    chk(rq, "msg_dest", o_d, d);
    chk(rq, "msg_bytes", o_b, bytes);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "req_ready", int'(req_ready), 1);
    chk("R1", "vic_ready", int'(vic_ready), 1);
    chk("R1", "msg_valid", int'(msg_valid), 0);
    chk("R1", "vic_done", int'(vic_done), 0);
    do_vic(6);  // fresh entry must be empty
    chk("R1", "fresh victim done", o_done, 1);
    chk("R1", "fresh victim silent", o_v, 0);
  endtask

  task automatic t_write_fresh();
    do_req(Q_WR, 0, 1);
    expect_msg("R2", T_GM, 4'b0001, 72);
    chk("R2", "msg_blk", o_blk, 1);
  endtask

  task automatic t_read_share();
    do_req(Q_RD, 1, 2);
    expect_msg("R3", T_GS, 4'b0010, 72);
    do_req(Q_RD, 2, 2);
    expect_msg("R3", T_GS, 4'b0100, 72);
  endtask

  task automatic t_steal_modified();
    do_req(Q_WR, 3, 1);
    expect_msg("R4", T_INV, 4'b0001, 8);
    chk("R10", "req_ready while waiting", int'(req_ready), 0);
    chk("R10", "vic_ready while waiting", int'(vic_ready), 0);
    do_ack(2);  // core 2 was not asked
    chk("R11", "stray ack gives no msg", o_v, 0);
    chk("R11", "still stalled", int'(req_ready), 0);
    do_ack(0);
    expect_msg("R11", T_GM, 4'b1000, 72);
    chk("R11", "ready after grant", int'(req_ready), 1);
  endtask

  task automatic t_write_shared();
    do_req(Q_WR, 1, 2);
    expect_msg("R4", T_INV, 4'b0100, 8);
    do_ack(2);
    expect_msg("R4", T_GM, 4'b0010, 72);
  endtask

  task automatic t_read_forward();
    do_req(Q_RD, 0, 2);
    expect_msg("R5", T_FWD, 4'b0010, 8);
    do_ack(1);
    expect_msg("R5", T_GS, 4'b0001, 72);
    do_vic(2);
    expect_msg("R8", T_RCL, 4'b0011, 8);
    do_ack(0);
    chk("R8", "done early", o_done, 0);
    chk("R8", "no msg mid recall", o_v, 0);
    do_ack(1);
    chk("R8", "done after last ack", o_done, 1);
    do_req(Q_WR, 2, 2);  // block freed, no holders left
    expect_msg("R8", T_GM, 4'b0100, 72);
  endtask

  task automatic t_writeback();
    do_req(Q_WB, 2, 2);
    expect_msg("R7", T_ACK, 4'b0100, 8);
    do_req(Q_RD, 3, 2);  // must not forward
    expect_msg("R7", T_GS, 4'b1000, 72);
  endtask

  task automatic t_upgrade();
    do_req(Q_WR, 3, 2);
    expect_msg("R2", T_GM, 4'b1000, 72);
  endtask

  task automatic t_clean_evict();
    do_req(Q_RD, 0, 3);
    do_req(Q_RD, 1, 3);
    do_req(Q_EV, 0, 3);
    expect_msg("R6", T_ACK, 4'b0001, 8);
    do_vic(3);
    expect_msg("R6", T_RCL, 4'b0010, 8);
    do_ack(1);
    chk("R6", "recall done", o_done, 1);
    do_req(Q_RD, 2, 4);
    do_req(Q_EV, 2, 4);
    expect_msg("R6", T_ACK, 4'b0100, 8);
    do_vic(4);
    chk("R6", "emptied victim done", o_done, 1);
    chk("R6", "emptied victim silent", o_v, 0);
  endtask

  task automatic t_victim_first();
    @(negedge clk);
    req_valid = 1'b1; req_type = Q_RD; req_core = CW'(1); req_blk = BW'(5);
    vic_valid = 1'b1; vic_blk = BW'(5);
    #1;
    chk("R12", "req_ready with victim", int'(req_ready), 0);
    @(negedge clk);
    vic_valid = 1'b0;
    chk("R12", "victim taken", int'(vic_done), 1);
    chk("R12", "request held", int'(msg_valid), 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    grab();
    expect_msg("R12", T_GS, 4'b0010, 72);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_fresh();
    t_read_share();
    t_steal_modified();
    t_write_shared();
    t_read_forward();
    t_writeback();
    t_upgrade();
    t_clean_evict();
    t_victim_first();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule